// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Unit

This block is the hazard logic of a five-stage integer pipeline whose branches and jumps are decided in the decode stage and are followed by one delay-slot instruction that always executes. It looks at the instruction words in the decode (ID), execute (EX), memory (MEM) and write-back (WB) stages, together with each older stage's register-write and memory-read flags. It works out which older result each younger instruction needs.

From that comparison it drives four selects. Two steer the ALU operand muxes in EX. The other two steer the operand muxes of the equality comparator that a branch-if-equal uses in ID. When no forwarding path can deliver a value in time, it raises a stall. The stall freezes the fetch and decode stages and loads a bubble into EX, while MEM and WB keep moving. All outputs are combinational functions of the current stage contents. A two-cycle wait therefore comes out as two consecutive one-cycle stalls.

Field positions: the major opcode is bits 31:26, the first source is bits 25:21, the second source or immediate-form destination is bits 20:16, and the register-form destination is bits 15:11. The register file is assumed to write in the first half of a cycle and read in the second, so WB values reach ID without a select.

Top module: `hazard_unit`

## Requirements
- R1: The destination is bits 15:11 when the major opcode is 000000 and bits 20:16 otherwise. Bits 25:21 are a source for every non-zero word except a jump (opcode 000010). Bits 20:16 are a source only for opcode 000000, a store (101011) and a branch-if-equal (000100).
- R2: Each EX operand select is 0 for the register file value, 1 for the EX/MEM result and 2 for the MEM/WB result. Operand A follows bits 25:21 and operand B follows bits 20:16 of the EX word.
- R3: When the MEM and WB stages both write the register an EX source names, the select is 1.
- R4: Register 0 never causes a non-zero select or a stall.
- R5: A load (memory-read set) in MEM never drives select 1. Such a source falls back to the WB match or to 0.
- R6: An ID instruction that reads the destination of a load in EX raises the stall and the bubble for that cycle.
- R7: For a branch-if-equal in ID, each comparator select (A for bits 25:21, B for bits 20:16) is 1 when a non-load MEM instruction writes that non-zero register, and 0 otherwise.
- R8: A branch-if-equal in ID that reads the destination of a non-load EX instruction stalls.
- R9: A branch-if-equal in ID that reads the destination of a load in MEM stalls. Together with R6, a branch right behind a load waits exactly two cycles.
- R10: A jump in ID never stalls, whatever its target bits hold.
- R11: No stall occurs in any other case. This covers a non-branch reading a non-load EX result, and a load in EX whose destination matches only the destination field of the ID word.
- R12: The bubble output equals the stall output in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idIr | input | 32 | Instruction word in ID |
| exIr | input | 32 | Instruction word in EX |
| memIr | input | 32 | Instruction word in MEM |
| wbIr | input | 32 | Instruction word in WB |
| exRegWr | input | 1 | EX instruction writes a register |
| exMemRd | input | 1 | EX instruction reads memory |
| memRegWr | input | 1 | MEM instruction writes a register |
| memMemRd | input | 1 | MEM instruction reads memory |
| wbRegWr | input | 1 | WB instruction writes a register |
| aluFwdA | output | 2 | EX operand A select |
| aluFwdB | output | 2 | EX operand B select |
| cmpFwdA | output | 1 | ID comparator operand A takes the EX/MEM result |
| cmpFwdB | output | 1 | ID comparator operand B takes the EX/MEM result |
| stallFront | output | 1 | Hold the fetch and decode stages |
| bubbleEx | output | 1 | Load a no-op into EX |

## Verification
Directed stage fillings come first. They put matching writers in MEM only, in WB only, and in both, which tells the three select codes and their priority apart. Register 0 and loads in MEM show that those cases are excluded from forwarding. For stalls, loads, ALU writers and jumps sit against a branch or a plain instruction in ID, and a destination-only match shows that a source match is required. A short program then runs through a bench pipeline that obeys the model's stalls. This checks that a branch right behind a load waits exactly two cycles, that a load-use pair waits one, and that an ALU-to-branch pair one apart is forwarded without a wait.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int IR_W  = 32;
  localparam int REG_W = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_JUMP  = 6'b000010;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_STORE = 6'b101011;

  typedef enum logic [1:0] {
    SEL_REG   = 2'd0,
    SEL_EXMEM = 2'd1,
    SEL_MEMWB = 2'd2
  } fwdSel_e;

  typedef struct packed {
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
    logic             useSrc1;
    logic             useSrc2;
    logic [REG_W-1:0] dst;
    logic             isBeq;
    logic             isJump;
  } regFields_t;

  typedef struct packed {
    logic stall;
    logic bubble;
  } hzdStrobe_t;

  function automatic logic readsReg(input regFields_t f, input logic [REG_W-1:0] r);
    return (r != '0) && ((f.useSrc1 && f.src1 == r) || (f.useSrc2 && f.src2 == r));
  endfunction
endpackage

// File: rtl/hzd_fieldDecode.sv
module hzd_fieldDecode
  import hzd_pkg::*;
(
  input  logic [IR_W-1:0] ir,
  output regFields_t      fields
);
  logic [5:0] op;
  logic       nonZero;

  assign op      = ir[31:26];
  assign nonZero = (ir != '0);

  always_comb begin
    fields.src1    = ir[25:21];
    fields.src2    = ir[20:16];
    fields.isJump  = (op == OP_JUMP);
    fields.isBeq   = (op == OP_BEQ);
    fields.useSrc1 = nonZero && !fields.isJump;
    fields.useSrc2 = nonZero && (op == OP_RTYPE || op == OP_STORE || op == OP_BEQ);
    fields.dst     = (op == OP_RTYPE) ? ir[15:11] : ir[20:16];
  end

  // R1
  always_comb begin
    fields_jump_chk: assert (!(fields.isJump && (fields.useSrc1 || fields.useSrc2)))
      else $error("jump word marked as reading a register");
  end
endmodule

// File: rtl/hzd_fwdPath.sv
module hzd_fwdPath
  import hzd_pkg::*;
(
  input  regFields_t idF,
  input  regFields_t exF,
  input  regFields_t memF,
  input  regFields_t wbF,
  input  logic       memRegWr,
  input  logic       memMemRd,
  input  logic       wbRegWr,
  output fwdSel_e    aluSel [2],
  output logic       cmpSel [2]
);
  logic memAlu;
  assign memAlu = memRegWr && !memMemRd;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    logic [REG_W-1:0] exSrc, idSrc;
    logic             exUse, idUse;

    assign exSrc = (k == 0) ? exF.src1 : exF.src2;
    assign exUse = (k == 0) ? exF.useSrc1 : exF.useSrc2;
    assign idSrc = (k == 0) ? idF.src1 : idF.src2;
    assign idUse = (k == 0) ? idF.useSrc1 : idF.useSrc2;

    always_comb begin
      aluSel[k] = SEL_REG;
      if (exUse && exSrc != '0) begin
        if (memAlu && memF.dst == exSrc)
          aluSel[k] = SEL_EXMEM;
        else if (wbRegWr && wbF.dst == exSrc)
          aluSel[k] = SEL_MEMWB;
      end
    end

    assign cmpSel[k] = idF.isBeq && idUse && idSrc != '0 && memAlu && memF.dst == idSrc;

    // R5
    always_comb begin
      load_no_exmem_chk: assert (!(aluSel[k] == SEL_EXMEM && memMemRd))
        else $error("load result in MEM forwarded to EX");
    end
    // R4
    always_comb begin
      zero_no_fwd_chk: assert (aluSel[k] == SEL_REG || exSrc != '0)
        else $error("register 0 forwarded");
    end
    // R7
    always_comb begin
      cmp_beq_only_chk: assert (!cmpSel[k] || (idF.isBeq && memRegWr))
        else $error("comparator select outside a branch");
    end
  end
endmodule

// File: rtl/hzd_stallCtrl.sv
module hzd_stallCtrl
  import hzd_pkg::*;
(
  input  regFields_t idF,
  input  regFields_t exF,
  input  regFields_t memF,
  input  logic       exRegWr,
  input  logic       exMemRd,
  input  logic       memRegWr,
  input  logic       memMemRd,
  output hzdStrobe_t strobe
);
  logic exLoad, memLoad, loadUse, brOnAlu, brOnMemLoad, anyStall;

  assign exLoad      = exRegWr && exMemRd;
  assign memLoad     = memRegWr && memMemRd;
  assign loadUse     = exLoad && readsReg(idF, exF.dst);
  assign brOnAlu     = idF.isBeq && exRegWr && !exMemRd && readsReg(idF, exF.dst);
  assign brOnMemLoad = idF.isBeq && memLoad && readsReg(idF, memF.dst);
  assign anyStall    = loadUse || brOnAlu || brOnMemLoad;

  assign strobe.stall  = anyStall;
  assign strobe.bubble = anyStall;

  // R10
  always_comb begin
    jump_no_stall_chk: assert (!(idF.isJump && strobe.stall))
      else $error("jump stalled");
  end
  // R6
  always_comb begin
    load_use_chk: assert (!(exLoad && exF.dst != '0 && idF.useSrc1 && idF.src1 == exF.dst) || strobe.stall)
      else $error("load-use hazard not stalled");
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hzd_pkg::*;
(
  input  logic [31:0] idIr,
  input  logic [31:0] exIr,
  input  logic [31:0] memIr,
  input  logic [31:0] wbIr,
  input  logic        exRegWr,
  input  logic        exMemRd,
  input  logic        memRegWr,
  input  logic        memMemRd,
  input  logic        wbRegWr,
  output logic [1:0]  aluFwdA,
  output logic [1:0]  aluFwdB,
  output logic        cmpFwdA,
  output logic        cmpFwdB,
  output logic        stallFront,
  output logic        bubbleEx
);
  localparam int NSTAGE = 4;

  logic [IR_W-1:0] stageIr [NSTAGE];
  regFields_t      stageF  [NSTAGE];
  fwdSel_e         aluSel  [2];
  logic            cmpSel  [2];
  hzdStrobe_t      strobe;

  assign stageIr[0] = idIr;
  assign stageIr[1] = exIr;
  assign stageIr[2] = memIr;
  assign stageIr[3] = wbIr;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_dec
    hzd_fieldDecode u_dec (.ir(stageIr[s]), .fields(stageF[s]));
  end

  hzd_fwdPath u_fwd (
    .idF(stageF[0]), .exF(stageF[1]), .memF(stageF[2]), .wbF(stageF[3]),
    .memRegWr(memRegWr), .memMemRd(memMemRd), .wbRegWr(wbRegWr),
    .aluSel(aluSel), .cmpSel(cmpSel)
  );

  hzd_stallCtrl u_ctl (
    .idF(stageF[0]), .exF(stageF[1]), .memF(stageF[2]),
    .exRegWr(exRegWr), .exMemRd(exMemRd), .memRegWr(memRegWr), .memMemRd(memMemRd),
    .strobe(strobe)
  );

  assign aluFwdA    = aluSel[0];
  assign aluFwdB    = aluSel[1];
  assign cmpFwdA    = cmpSel[0];
  assign cmpFwdB    = cmpSel[1];
  assign stallFront = strobe.stall;
  assign bubbleEx   = strobe.bubble;

  // R12
  always_comb begin
    bubble_match_chk: assert (bubbleEx == stallFront)
      else $error("bubble and stall disagree");
  end
  // R4
  always_comb begin
    zero_cmp_chk: assert (!(cmpFwdA && idIr[25:21] == 5'd0))
      else $error("register 0 sent to comparator");
  end
endmodule

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] idIr, exIr, memIr, wbIr;
  logic exRegWr, exMemRd, memRegWr, memMemRd, wbRegWr;
  logic [1:0] aluFwdA, aluFwdB;
  logic cmpFwdA, cmpFwdB, stallFront, bubbleEx;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  hazard_unit u0 (.*);

  function automatic logic [31:0] rtype(int rs, int rt, int rd);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'b100000};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt);
    return {op, rs[4:0], rt[4:0], 16'h0004};
  endfunction
  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100,
                         JMP = 6'b000010, ADDI = 6'b001000;

  function automatic bit writesOf(logic [31:0] w);
    return w[31:26] == 6'd0 || w[31:26] == LW || w[31:26] == ADDI;
  endfunction

  // reference: which registers a word reads, written from the requirement text
  function automatic bit reads(logic [31:0] w, int r);
    int a, b; bit ua, ub;
    if (r == 0 || w == 0) return 0;
    a = w[25:21]; b = w[20:16];
    ua = (w[31:26] != JMP);
    ub = (w[31:26] == 6'd0) || (w[31:26] == SW) || (w[31:26] == BEQ);
    return (ua && a == r) || (ub && b == r);
  endfunction
  function automatic int dstOf(logic [31:0] w);
    if (w[31:26] == 6'd0) return w[15:11];
    return w[20:16];
  endfunction

  function automatic logic [7:0] expected();
    int s[2]; int sel[2]; bit cmp[2]; bit st;
    bit isBeq = (idIr[31:26] == BEQ);
    bit memAlu = memRegWr && !memMemRd;
    s[0] = exIr[25:21]; s[1] = exIr[20:16];
    for (int k = 0; k < 2; k++) begin
      bit used = (exIr != 0) && (k == 0 ? exIr[31:26] != JMP :
                 (exIr[31:26] == 0 || exIr[31:26] == SW || exIr[31:26] == BEQ));
      sel[k] = 0;
      if (used && s[k] != 0) begin
        if (memAlu && dstOf(memIr) == s[k]) sel[k] = 1;
        else if (wbRegWr && dstOf(wbIr) == s[k]) sel[k] = 2;
      end
      cmp[k] = isBeq && memAlu && (k == 0 ? idIr[25:21] : idIr[20:16]) != 0 &&
               dstOf(memIr) == (k == 0 ? idIr[25:21] : idIr[20:16]);
    end
    st = 0;
    if (exRegWr && exMemRd && reads(idIr, dstOf(exIr))) st = 1;
    if (isBeq && exRegWr && !exMemRd && reads(idIr, dstOf(exIr))) st = 1;
    if (isBeq && memRegWr && memMemRd && reads(idIr, dstOf(memIr))) st = 1;
    return {sel[0][1:0], sel[1][1:0], cmp[0], cmp[1], st, st};
  endfunction

  task automatic setStages(logic [31:0] i, logic [31:0] e, logic [31:0] m, logic [31:0] w);
    idIr = i; exIr = e; memIr = m; wbIr = w;
    exRegWr = writesOf(e); exMemRd = (e[31:26] == LW);
    memRegWr = writesOf(m); memMemRd = (m[31:26] == LW);
    wbRegWr = writesOf(w);
  endtask

  task automatic check(string tag, logic [7:0] exp);
    logic [7:0] act = {aluFwdA, aluFwdB, cmpFwdA, cmpFwdB, stallFront, bubbleEx};
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic probe(string tag, logic [31:0] i, logic [31:0] e, logic [31:0] m, logic [31:0] w);
    @(posedge clk); setStages(i, e, m, w); #2;
    check(tag, expected());
  endtask

  initial begin
    #200000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] prog[$];
    logic [31:0] pid, pex, pmem, pwb;
    int stalls, beqStalls, cmpSeen;
    setStages(0, 0, 0, 0);
    #2 check("R11 idle", 8'h00);
    probe("R2 exmem", 0, rtype(1, 2, 3), rtype(4, 4, 1), 0);
    check("R2 exmem literal", 8'b01_00_0_0_0_0);
    probe("R2 memwb", 0, rtype(1, 2, 3), 0, itype(ADDI, 0, 2));
    check("R2 memwb literal", 8'b00_10_0_0_0_0);
    probe("R3 priority", 0, rtype(1, 1, 3), rtype(5, 5, 1), rtype(6, 6, 1));
    check("R3 priority literal", 8'b01_01_0_0_0_0);
    probe("R4 zero", itype(BEQ, 0, 0), rtype(0, 0, 3), rtype(5, 5, 0), rtype(6, 6, 0));
    check("R4 zero literal", 8'h00);
    probe("R5 load in mem", 0, rtype(1, 2, 3), itype(LW, 9, 1), 0);
    check("R5 load literal", 8'h00);
    probe("R5 falls to wb", 0, rtype(1, 2, 3), itype(LW, 9, 1), rtype(7, 7, 1));
    check("R5 fall literal", 8'b10_00_0_0_0_0);
    probe("R6 load use", rtype(4, 8, 9), itype(LW, 1, 4), 0, 0);
    check("R6 literal", 8'b00_00_0_0_1_1);
    probe("R1 store reads rt", itype(SW, 1, 4), itype(LW, 1, 4), 0, 0);
    check("R1 store literal", 8'b00_00_0_0_1_1);
    probe("R1 addi rt is dest", itype(ADDI, 9, 4), itype(LW, 1, 4), 0, 0);
    check("R11 dest only literal", 8'h00);
    probe("R7 cmp fwd", itype(BEQ, 6, 7), 0, rtype(1, 1, 7), 0);
    check("R7 literal", 8'b00_00_0_1_0_0);
    probe("R8 beq on alu", itype(BEQ, 6, 7), rtype(1, 1, 6), 0, 0);
    check("R8 literal", 8'b00_00_0_0_1_1);
    probe("R9 beq on mem load", itype(BEQ, 6, 7), 0, itype(LW, 1, 6), 0);
    check("R9 literal", 8'b00_00_0_0_1_1);
    probe("R10 jump", {JMP, 5'd5, 5'd5, 16'h0}, itype(LW, 1, 5), itype(LW, 1, 5), 0);
    check("R10 literal", 8'h00);
    probe("R11 alu to plain", rtype(5, 2, 3), rtype(1, 1, 5), 0, 0);
    check("R11 alu literal", 8'h00);

    // program through a bench pipeline that obeys the reference stalls (R12 on every row)
    prog = '{itype(LW, 1, 5), itype(BEQ, 5, 2), 32'h0, itype(LW, 1, 6), rtype(6, 1, 7),
             rtype(7, 7, 10), itype(ADDI, 0, 11), 32'h0, itype(BEQ, 11, 0), 32'h0,
             {JMP, 26'h2A}, 32'h0};
    pid = 0; pex = 0; pmem = 0; pwb = 0;
    stalls = 0; beqStalls = 0; cmpSeen = 0;
    for (int c = 0; c < 24; c++) begin
      logic [7:0] e;
      @(posedge clk);
      setStages(pid, pex, pmem, pwb); #2;
      e = expected();
      check("R12 pipeline row", e);
      if (e[1]) begin
        stalls++;
        if (pid[31:26] == BEQ) beqStalls++;
        pwb = pmem; pmem = pex; pex = 0;
      end else begin
        if (e[3] || e[2]) cmpSeen++;
        pwb = pmem; pmem = pex; pex = pid;
        pid = (prog.size() > 0) ? prog.pop_front() : 32'h0;
      end
    end
    nChecks++;
    if (beqStalls != 2) begin nFail++; $display("FAIL R9 branch wait: actual %0d expected 2", beqStalls); end
    nChecks++;
    if (stalls != 3) begin nFail++; $display("FAIL R6 total stalls: actual %0d expected 3", stalls); end
    nChecks++;
    if (cmpSeen != 1) begin nFail++; $display("FAIL R7 cmp forwards: actual %0d expected 1", cmpSeen); end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule